// File: doc/BRIEF.md
# Multi-core inter-processor interrupt register bank

This block holds the inter-processor interrupt state for a cluster of cores. Every core owns a bank made of a pending-status word, an enable word and an eight-word mailbox. Each core also drives one level-sensitive interrupt line. Requests arrive on a 32-bit register port. A requester index that travels with each request picks the bank that the request reaches. Software on one core posts messages into its own mailbox. It raises interrupts on itself through a bit-set register and acknowledges them through a bit-clear register.

A dedicated post register lets any requester raise a pending bit on another core. The write carries an architectural core ID and a 5-bit vector number. A parameter table maps architectural IDs to bank indices, and the search through it is combinational. If no bank matches the ID, the request is answered with an error flag and nothing changes.

The interrupt line is not a plain function of status and enable. It is raised by a set or a post that leaves an enabled bit pending. It is lowered only by a clear that empties status while enable is nonzero. Writing the enable word never moves the line.

Top module: `xcore_ipi_regs`

## Requirements
- R1: After reset, and after any later reset, every status word, enable word and mailbox word reads zero, every interrupt line is low and no response is pending.
- R2: Every request is answered by rsp_valid high in the next cycle, and only then. Only address bits 7:2 select a register, so upper address bits and bits 1:0 are ignored. rsp_rdata is zero for writes.
- R3: A write to the set register (offset 0x08) ORs the write data into the requester's status. The line is raised if the resulting status ANDed with enable is nonzero; otherwise the line keeps its value.
- R4: A write to the clear register (offset 0x0C) removes the written bits from status. The line is lowered only if the new status is zero and enable is nonzero, and otherwise it keeps its value.
- R5: The enable register (offset 0x04) is read/write. Writing it stores the value and leaves the interrupt line unchanged.
- R6: The status register (offset 0x00) is read-only. A write to it leaves status unchanged and gets a normal response without error.
- R7: Reads of the set, clear and post registers (offsets 0x08, 0x0C, 0x40) return zero.
- R8: Offsets 0x20 to 0x3C hold eight read/write 32-bit mailbox words per core, and word k sits at offset 0x20 + 4k.
- R9: A write to the post register (offset 0x40) takes a target ID from data bits 25:16 and a vector from bits 4:0. It acts as a set-register write of 1 << vector on the bank whose table ID matches, with the R3 rule for the line. The requester's own bank is untouched.
- R10: A post whose target ID matches no table entry answers with rsp_err high and changes no state. No other request sets rsp_err.
- R11: A read of any other offset returns zero without error, and a write to it changes nothing.
- R12: req_src selects the bank a request reaches, so banks of different cores hold independent values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; only bits 7:2 are decoded |
| req_src | input | SRC_W | Index of the requesting core's bank |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response, one cycle after the request |
| rsp_rdata | output | 32 | Read data, zero for writes |
| rsp_err | output | 1 | Post to an unknown target ID |
| irq | output | NUM_CORES | Level interrupt line per core |

## Verification
The set path is tried with bits that are pending but not enabled, which must leave the line low, and then with an enabled bit, which must raise it. This separates an AND with enable from a plain nonzero test. Clears are tried in partial and complete form, with enable zero and nonzero, which exposes the asymmetric lowering rule. An enable write is made while the line is high, which shows that enable writes do not re-evaluate the line. Posts are sent to two different matching IDs and to one missing ID, and mailboxes of two cores are filled with distinct words, which exposes wrong routing, wrong indexing and state changes on a failed post.

// File: rtl/ipi_pkg.sv
// Shared constants and types for the inter-processor interrupt bank.
// Assumes a 32-bit data path and an 8-bit register window (address bits 7:0).
package ipi_pkg;
    localparam int DATA_W     = 32;
    localparam int TID_W      = 10;   // width of the target ID field of a post
    localparam int TID_LSB    = 16;   // low bit of the target ID field
    localparam int VEC_W      = 5;    // width of the vector field of a post
    localparam int MBOX_WORDS = 8;
    localparam int MBOX_IW    = $clog2(MBOX_WORDS);

    // word addresses (byte offset >> 2)
    localparam logic [5:0] W_PEND  = 6'h00;
    localparam logic [5:0] W_ENA   = 6'h01;
    localparam logic [5:0] W_SETB  = 6'h02;
    localparam logic [5:0] W_CLRB  = 6'h03;
    localparam logic [5:0] W_POST  = 6'h10;
    localparam logic [2:0] W_MBOX_HI = 3'b001;  // words 0x08..0x0F

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_ENA,
        SEL_SETB,
        SEL_CLRB,
        SEL_MBOX,
        SEL_POST
    } reg_sel_e;
endpackage

// File: rtl/ipi_decode.sv
// Offset decoder: maps the low address byte onto a register selector and a
// mailbox word index. Assumes bits 1:0 of the offset are don't-care.
module ipi_decode
    import ipi_pkg::*;
(
    input  logic [7:0]         offset,
    output reg_sel_e           sel,
    output logic [MBOX_IW-1:0] mbox_idx
);
    logic [5:0] word;
    assign word     = offset[7:2];
    assign mbox_idx = word[MBOX_IW-1:0];

    // choose the register addressed by the word
    always_comb begin
        if (word[5:3] == W_MBOX_HI) sel = SEL_MBOX;
        else begin
            case (word)
                W_PEND:  sel = SEL_PEND;
                W_ENA:   sel = SEL_ENA;
                W_SETB:  sel = SEL_SETB;
                W_CLRB:  sel = SEL_CLRB;
                W_POST:  sel = SEL_POST;
                default: sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ipi_target_lookup.sv
// Target search: compares a target ID with every entry of the ID table in
// parallel and returns the lowest matching bank index.
// Assumes entry i of ID_TABLE (bits i*TID_W +: TID_W) belongs to bank i.
module ipi_target_lookup
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int SRC_W     = 2,
    parameter logic [NUM_CORES*TID_W-1:0] ID_TABLE = '0
) (
    input  logic [TID_W-1:0] tgt_id,
    output logic             hit,
    output logic [SRC_W-1:0] tgt_idx
);
    // scan from the top so the lowest matching index wins
    always_comb begin
        hit     = 1'b0;
        tgt_idx = '0;
        for (int i = NUM_CORES - 1; i >= 0; i--) begin
            if (ID_TABLE[i*TID_W +: TID_W] == tgt_id) begin
                hit     = 1'b1;
                tgt_idx = SRC_W'(i);
            end
        end
    end
endmodule

// File: rtl/ipi_core_bank.sv
// One core's bank: pending status, enable, mailbox and the interrupt level.
// Assumes at most one of the strobes is high in a cycle.
module ipi_core_bank
    import ipi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_stb,
    input  logic [DATA_W-1:0]  set_bits,
    input  logic               clr_stb,
    input  logic               ena_stb,
    input  logic               mbox_stb,
    input  logic [MBOX_IW-1:0] mbox_idx,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  pend_o,
    output logic [DATA_W-1:0]  ena_o,
    output logic [DATA_W-1:0]  mbox_o,
    output logic               irq_o
);
    logic [DATA_W-1:0] pend, ena;
    logic [DATA_W-1:0] mbox [MBOX_WORDS];
    logic [DATA_W-1:0] pend_set, pend_clr;

    assign pend_set = pend | set_bits;
    assign pend_clr = pend & ~wdata;

    // status word and the asymmetric raise/lower rule for the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= '0;
            irq_o <= 1'b0;
        end else if (set_stb) begin
            pend <= pend_set;
            if ((pend_set & ena) != '0) irq_o <= 1'b1;
        end else if (clr_stb) begin
            pend <= pend_clr;
            if (pend_clr == '0 && ena != '0) irq_o <= 1'b0;
        end
    end

    // enable word: stored only, the line is not re-evaluated
    always_ff @(posedge clk) begin
        if (!rst_n)       ena <= '0;
        else if (ena_stb) ena <= wdata;
    end

    // mailbox words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < MBOX_WORDS; k++) mbox[k] <= '0;
        end else if (mbox_stb) begin
            mbox[mbox_idx] <= wdata;
        end
    end

    assign pend_o = pend;
    assign ena_o  = ena;
    assign mbox_o = mbox[mbox_idx];
endmodule

// File: rtl/xcore_ipi_regs.sv
// Top of the inter-processor interrupt bank: decodes requests, routes them to
// the requester's bank or, for a post, to the looked-up target bank, and
// returns a registered response one cycle later.
// Assumes one request per cycle and NUM_CORES >= 2.
module xcore_ipi_regs
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 12,
    parameter logic [NUM_CORES*TID_W-1:0] ID_TABLE = {10'd7, 10'd5, 10'd2, 10'd0},
    localparam int SRC_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [SRC_W-1:0]     req_src,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 rsp_err,
    output logic [NUM_CORES-1:0] irq
);
    reg_sel_e           sel;
    logic [MBOX_IW-1:0] mbox_idx;
    logic               tgt_hit;
    logic [SRC_W-1:0]   tgt_idx;
    logic               src_ok, wr;
    logic [DATA_W-1:0]  post_bits, rd_data;
    logic [NUM_CORES-1:0][DATA_W-1:0] pend_all, ena_all, mbox_all;
    logic unused_addr;

    assign unused_addr = &{1'b0, req_addr[ADDR_W-1:8]};
    assign src_ok      = int'(req_src) < NUM_CORES;
    assign wr          = req_valid && req_write && src_ok;
    assign post_bits   = DATA_W'(1) << req_wdata[VEC_W-1:0];

    ipi_decode u_decode (
        .offset   (req_addr[7:0]),
        .sel      (sel),
        .mbox_idx (mbox_idx)
    );

    ipi_target_lookup #(
        .NUM_CORES (NUM_CORES),
        .SRC_W     (SRC_W),
        .ID_TABLE  (ID_TABLE)
    ) u_lookup (
        .tgt_id  (req_wdata[TID_LSB +: TID_W]),
        .hit     (tgt_hit),
        .tgt_idx (tgt_idx)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_bank
        logic own, set_own, set_post;
        assign own      = wr && (req_src == SRC_W'(c));
        assign set_own  = own && (sel == SEL_SETB);
        assign set_post = wr && (sel == SEL_POST) && tgt_hit && (tgt_idx == SRC_W'(c));

        ipi_core_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_stb  (set_own || set_post),
            .set_bits (set_post ? post_bits : req_wdata),
            .clr_stb  (own && (sel == SEL_CLRB)),
            .ena_stb  (own && (sel == SEL_ENA)),
            .mbox_stb (own && (sel == SEL_MBOX)),
            .mbox_idx (mbox_idx),
            .wdata    (req_wdata),
            .pend_o   (pend_all[c]),
            .ena_o    (ena_all[c]),
            .mbox_o   (mbox_all[c]),
            .irq_o    (irq[c])
        );
    end

    // read multiplexer over the requester's bank
    always_comb begin
        rd_data = '0;
        if (src_ok) begin
            case (sel)
                SEL_PEND: rd_data = pend_all[req_src];
                SEL_ENA:  rd_data = ena_all[req_src];
                SEL_MBOX: rd_data = mbox_all[req_src];
                default:  rd_data = '0;
            endcase
        end
    end

    // registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rd_data : '0;
            rsp_err   <= wr && (sel == SEL_POST) && !tgt_hit;
        end
    end
endmodule

// File: rtl/ipi_checker.sv
// Protocol checker for xcore_ipi_regs: response timing, error source and the
// causes of every interrupt edge. Observes ports only.
module ipi_checker
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [7:0]           req_off,
    input  logic                 rsp_valid,
    input  logic [DATA_W-1:0]    rsp_rdata,
    input  logic                 rsp_err,
    input  logic [NUM_CORES-1:0] irq
);
    logic [5:0] w;
    assign w = req_off[7:2];

    assert_resp_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_resp_caused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    assert_err_post_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid && $past(req_write && w == W_POST));

    assert_wo_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(!req_write && (w == W_SETB || w == W_CLRB || w == W_POST)))
        |-> rsp_rdata == '0);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_line
        assert_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[c]) |-> $past(req_valid && req_write && (w == W_SETB || w == W_POST)));

        assert_fall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[c]) |-> $past(req_valid && req_write && w == W_CLRB));

        assert_ena_no_move_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(req_valid && req_write && w == W_ENA) |-> $stable(irq[c]));
    end
endmodule

bind xcore_ipi_regs ipi_checker #(.NUM_CORES(NUM_CORES)) u_ipi_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_off   (req_addr[7:0]),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .irq       (irq)
);

// File: tb/xcore_ipi_regs_bench.sv
// Bench: behavioural reference model, compared with the outputs every cycle.
module xcore_ipi_regs_bench;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_src = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [NC-1:0] irq;

    xcore_ipi_regs u_xcore_ipi_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_src(req_src), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq(irq)
    );

    always #10 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    int unsigned m_pend [NC];
    int unsigned m_ena  [NC];
    int unsigned m_mb   [NC][8];
    logic [NC-1:0] m_irq = '0;
    int          m_ids [NC] = '{0, 2, 5, 7};
    logic        e_valid = 1'b0, e_err = 1'b0;
    logic [31:0] e_rdata = '0;
    string       e_tag = "R1";

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(rsp_valid === e_valid, e_tag, "rsp_valid", rsp_valid, e_valid);
        chk(irq === m_irq, e_tag, "irq", irq, m_irq);
        if (e_valid) begin
            chk(rsp_rdata === e_rdata, e_tag, "rsp_rdata", rsp_rdata, e_rdata);
            chk(rsp_err === e_err, e_tag, "rsp_err", rsp_err, e_err);
        end
    endtask

    task automatic m_set(int t, int unsigned bits);
        m_pend[t] |= bits;
        if ((m_pend[t] & m_ena[t]) != 0) m_irq[t] = 1'b1;
    endtask

    task automatic m_clr(int t, int unsigned bits);
        m_pend[t] &= ~bits;
        if (m_pend[t] == 0 && m_ena[t] != 0) m_irq[t] = 1'b0;
    endtask

    task automatic model(bit w, logic [11:0] a, int s, int unsigned d);
        int unsigned off = a[7:0] & 8'hFC;
        e_rdata = '0;
        e_err   = 1'b0;
        if (!w) begin
            if (off == 'h00) e_rdata = m_pend[s];
            else if (off == 'h04) e_rdata = m_ena[s];
            else if (off >= 'h20 && off <= 'h3C) e_rdata = m_mb[s][(off - 'h20) >> 2];
        end else begin
            if (off == 'h04) m_ena[s] = d;
            else if (off == 'h08) m_set(s, d);
            else if (off == 'h0C) m_clr(s, d);
            else if (off >= 'h20 && off <= 'h3C) m_mb[s][(off - 'h20) >> 2] = d;
            else if (off == 'h40) begin
                int t = -1;
                for (int i = NC - 1; i >= 0; i--) if (m_ids[i] == int'((d >> 16) & 'h3FF)) t = i;
                if (t < 0) e_err = 1'b1;
                else m_set(t, 32'h1 << (d & 31));
            end
        end
    endtask

    task automatic tick(bit v, bit w, logic [11:0] a, int s, int unsigned d, string tag);
        @(negedge clk);
        compare();
        req_valid = v; req_write = w; req_addr = a; req_src = 2'(s); req_wdata = d;
        e_valid = v;
        e_tag   = tag;
        if (v) model(w, a, s, d);
    endtask

    task automatic wr(logic [11:0] a, int s, int unsigned d, string tag);
        tick(1'b1, 1'b1, a, s, d, tag);
    endtask

    task automatic rd(logic [11:0] a, int s, string tag);
        tick(1'b1, 1'b0, a, s, 0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            m_pend[c] = 0; m_ena[c] = 0;
            for (int k = 0; k < 8; k++) m_mb[c][k] = 0;
        end
        m_irq = '0; e_valid = 1'b0; e_tag = "R1";
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        tick(0, 0, 0, 0, 0, "R1");
        // R1: reset values
        for (int c = 0; c < NC; c++) begin
            rd('h000, c, "R1"); rd('h004, c, "R1"); rd('h03C, c, "R1");
        end
        // R5, R3: set bits that are not enabled, then an enabled one
        wr('h004, 0, 32'h3, "R5");
        rd('h004, 0, "R5");
        wr('h008, 0, 32'h4, "R3");
        rd('h000, 0, "R3");
        wr('h008, 0, 32'h1, "R3");
        rd('h008, 0, "R7");
        rd('h00C, 0, "R7");
        rd('h040, 0, "R7");
        // R6: status write ignored
        wr('h000, 0, 32'hFFFF, "R6");
        rd('h000, 0, "R6");
        // R4: partial clear keeps the line, full clear lowers it
        wr('h00C, 0, 32'h1, "R4");
        rd('h000, 0, "R4");
        wr('h00C, 0, 32'h4, "R4");
        // R5, R4: enable write while high, clear with enable zero
        wr('h004, 1, 32'h1, "R5");
        wr('h008, 1, 32'h1, "R3");
        wr('h004, 1, 32'h0, "R5");
        wr('h00C, 1, 32'h1, "R4");
        wr('h004, 1, 32'h1, "R5");
        wr('h00C, 1, 32'h0, "R4");
        // R8, R12: mailboxes of two cores
        for (int k = 0; k < 8; k++) wr(12'(32'h20 + 4 * k), 2, 32'hA500_0000 + k * 32'h1111, "R8");
        wr('h024, 3, 32'h1234_5678, "R12");
        for (int k = 0; k < 8; k++) rd(12'(32'h20 + 4 * k), 2, "R8");
        rd('h024, 3, "R12");
        rd('h020, 3, "R12");
        // R2: upper and low address bits ignored
        rd('h527, 2, "R2");
        wr('hF06, 3, 32'h55, "R2");
        rd('h004, 3, "R2");
        // R9: posts to matching IDs
        wr('h004, 2, 32'h8000_0000, "R9");
        wr('h040, 0, (32'd5 << 16) | 32'd31, "R9");
        rd('h000, 2, "R9");
        rd('h000, 0, "R9");
        wr('h004, 3, 32'h0, "R9");
        wr('h040, 1, (32'd7 << 16) | 32'd3, "R9");
        rd('h000, 3, "R9");
        // R10: post to a missing ID
        wr('h040, 0, (32'd3 << 16) | 32'd6, "R10");
        for (int c = 0; c < NC; c++) rd('h000, c, "R10");
        // R11: undecoded offsets
        wr('h010, 1, 32'hFFFF_FFFF, "R11");
        wr('h044, 1, 32'hFFFF_FFFF, "R11");
        wr('h080, 1, 32'hFFFF_FFFF, "R11");
        rd('h010, 1, "R11");
        rd('h0FC, 1, "R11");
        rd('h000, 1, "R11");
        rd('h004, 1, "R11");
        // R1: reset again clears all state
        do_reset();
        tick(0, 0, 0, 0, 0, "R1");
        rd('h000, 2, "R1");
        rd('h004, 2, "R1");
        rd('h020, 2, "R1");
        tick(0, 0, 0, 0, 0, "R1");
        tick(0, 0, 0, 0, 0, "R1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule